// File: doc/BRIEF.md
# Serial DAC Loading Interface

This block is the digital front end of a 16-bit voltage-output converter. A host shifts a 16-bit code into it over a three- or four-wire serial port: an active-low chip select frames each word, and the serial clock's rising edge captures one data bit, most significant bit first. A complete word lands in an input register. It moves on into a separate holding register, which drives the converter, in one of two ways. If the load input is low when chip select rises, the move happens at the end of the frame. Otherwise it happens later, when the load input falls. A host can therefore preload the next code without disturbing the present output.

The held code is split for a segmented converter core. The upper four bits become 15 thermometer-coded segment enables. The lower twelve bits pass straight through to a binary ladder. All four serial-side inputs are sampled by a faster system clock through two-flop synchronizers, and that clock must run at least four times faster than the serial clock. A one-cycle pulse marks every update of the holding register.

Top module: `serdac_loader`

## Requirements
- R1: A frame starts on a falling edge of chip select. Serial clock edges seen while chip select is high shift nothing and do not count toward a frame.
- R2: While chip select is low, each rising serial clock edge captures one data bit. Bits enter most significant first, so the first bit of a frame ends up in bit 15.
- R3: When chip select rises after exactly 16 captured bits and the load input is low, the holding register takes the new word. `dac_upd` is high for exactly that one cycle.
- R4: When chip select rises after exactly 16 bits and the load input is high, only the input register takes the word. It is marked pending, and `dac_word` stays unchanged.
- R5: A falling edge on the load input while a word is pending copies the input register into the holding register, pulses `dac_upd` and clears the pending mark. A later pending word overwrites an earlier one.
- R6: A falling edge on the load input with no word pending changes nothing and produces no pulse.
- R7: While reset is asserted, `dac_word`, `seg_en` and `ladder` are zero and `dac_upd` is low.
- R8: `seg_en[i]` is 1 exactly when `dac_word[15:12]` is greater than i, for i = 0 to 14. The number of asserted enables therefore equals the value of the top four bits.
- R9: `ladder` equals `dac_word[11:0]`.
- R10: A frame that ends with any bit count other than 16 is discarded. Neither register changes, and an earlier pending word stays pending unchanged.
- R11: `dac_word` changes only in a cycle in which `dac_upd` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low frame select (asynchronous) |
| sclk | input | 1 | Serial bit clock (asynchronous) |
| sdi | input | 1 | Serial data, MSB first (asynchronous) |
| ld_n | input | 1 | Load input: low at frame end means immediate transfer, falling edge means deferred transfer |
| dac_word | output | 16 | Holding register value |
| seg_en | output | 15 | Thermometer segment enables from the top 4 bits |
| ladder | output | 12 | Binary ladder bits from the low 12 bits |
| dac_upd | output | 1 | One-cycle pulse on each holding register update |

## Verification
The bench sends frames of 15 and 17 bits. A design that counted loosely would load a shifted word; a discarded short frame that still touched the input register would show up when a later strobe releases the wrong pending code. It strobes the load input with nothing pending and expects silence, which catches a design that reloads a stale input register. It preloads two words before a single strobe, so keeping the first word is caught. It also drives codes 0x0000, 0xFFFF and 0x8001, which expose an off-by-one thermometer decode or a swapped segment and ladder split.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  // Edge events seen on the synchronized serial-side inputs.
  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic sclk_rise;
    logic ld_fall;
  } sdl_edges_t;
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[s] <= RST_VAL;
        end else if (s == 0) begin
          stg_q[s] <= d;
        end else begin
          stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sdl_shifter.sv
module sdl_shifter
  import sdl_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdl_edges_t        ev,
  input  logic              cs_lvl,
  input  logic              sdi_lvl,
  output logic              frame_ok,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ok_q, ok_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    ok_d  = 1'b0;
    if (ev.cs_fall) begin
      cnt_d = '0;
    end else if (!cs_lvl && ev.sclk_rise) begin
      sh_d = {sh_q[WORD_W-2:0], sdi_lvl};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
    if (ev.cs_rise && (cnt_q == CNT_FULL)) ok_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
    end
  end

  assign frame_ok = ok_q;
  assign word     = sh_q;
endmodule

// File: rtl/sdl_hold.sv
module sdl_hold #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  logic [WORD_W-1:0] word,
  input  logic              ld_lvl,
  input  logic              ld_fall,
  output logic [WORD_W-1:0] dac_word,
  output logic              dac_upd,
  output logic              pending
);
  logic [WORD_W-1:0] in_q, in_d, dac_q, dac_d;
  logic              pend_q, pend_d, upd_q, upd_d;

  always_comb begin
    in_d   = in_q;
    dac_d  = dac_q;
    pend_d = pend_q;
    upd_d  = 1'b0;
    if (frame_ok) begin
      in_d = word;
      if (!ld_lvl) begin
        dac_d  = word;
        pend_d = 1'b0;
        upd_d  = 1'b1;
      end else begin
        pend_d = 1'b1;
      end
    end else if (ld_fall && pend_q) begin
      dac_d  = in_q;
      pend_d = 1'b0;
      upd_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      dac_q  <= '0;
      pend_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      in_q   <= in_d;
      pend_q <= pend_d;
      upd_q  <= upd_d;
      if (upd_d) dac_q <= dac_d;
    end
  end

  assign dac_word = dac_q;
  assign dac_upd  = upd_q;
  assign pending  = pend_q;
endmodule

// File: rtl/sdl_thermo.sv
module sdl_thermo #(
  parameter int SEG_BITS = 4,
  localparam int SEG_N   = (1 << SEG_BITS) - 1
) (
  input  logic [SEG_BITS-1:0] code,
  output logic [SEG_N-1:0]    seg_en
);
  generate
    for (genvar i = 0; i < SEG_N; i++) begin : g_seg
      assign seg_en[i] = (code > SEG_BITS'(i));
    end
  endgenerate
endmodule

// File: rtl/serdac_loader.sv
module serdac_loader
  import sdl_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SEG_BITS    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int LADDER_W   = WORD_W - SEG_BITS,
  localparam int SEG_N      = (1 << SEG_BITS) - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                sdi,
  input  logic                ld_n,
  output logic [WORD_W-1:0]   dac_word,
  output logic [SEG_N-1:0]    seg_en,
  output logic [LADDER_W-1:0] ladder,
  output logic                dac_upd
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // Bit order of the synchronized vector: {ld, sdi, sclk, cs}; idle levels 1,0,0,1.
  logic [3:0] raw, syn;
  assign raw = {ld_n, sdi, sclk, cs_n};

  sdl_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(raw), .q(syn)
  );

  logic cs_p, sclk_p, ld_p;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cs_p   <= 1'b1;
      sclk_p <= 1'b0;
      ld_p   <= 1'b1;
    end else begin
      cs_p   <= syn[0];
      sclk_p <= syn[1];
      ld_p   <= syn[3];
    end
  end

  sdl_edges_t ev;
  always_comb begin
    ev.cs_fall   = cs_p & ~syn[0];
    ev.cs_rise   = ~cs_p & syn[0];
    ev.sclk_rise = ~sclk_p & syn[1];
    ev.ld_fall   = ld_p & ~syn[3];
  end

  logic              frame_ok;
  logic [WORD_W-1:0] frame_word;
  logic              pend;

  sdl_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .ev(ev), .cs_lvl(syn[0]), .sdi_lvl(syn[2]),
    .frame_ok(frame_ok), .word(frame_word)
  );

  sdl_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .frame_ok(frame_ok), .word(frame_word),
    .ld_lvl(syn[3]), .ld_fall(ev.ld_fall),
    .dac_word(dac_word), .dac_upd(dac_upd), .pending(pend)
  );

  sdl_thermo #(.SEG_BITS(SEG_BITS)) u_thermo (
    .code(dac_word[WORD_W-1 -: SEG_BITS]), .seg_en(seg_en)
  );

  assign ladder = dac_word[LADDER_W-1:0];
endmodule

// File: rtl/serdac_loader_chk.sv
module serdac_loader_chk #(
  parameter int WORD_W = 16,
  parameter int SEG_N  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] dac_word,
  input logic [SEG_N-1:0]  seg_en,
  input logic              dac_upd,
  input logic              ld_fall,
  input logic              pend,
  input logic              frame_ok
);
  // R7: reset holds the outputs at zero
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r7_reset_zero: assert (dac_word == '0 && seg_en == '0 && !dac_upd);
    end
  end

  // R11: holding register moves only with the update pulse
  a_r11_hold_between_updates: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_upd |-> dac_word == $past(dac_word));

  // R8: number of enables equals the top field
  a_r8_seg_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_en) == int'(dac_word[WORD_W-1 -: 4]));

  // R8: enables form a contiguous run from bit 0
  a_r8_seg_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_en & (seg_en + 1'b1)) == '0);

  // R6: a load strobe with nothing pending produces no update
  a_r6_no_pending_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fall && !pend && !frame_ok) |=> !dac_upd);
endmodule

bind serdac_loader serdac_loader_chk #(.WORD_W(WORD_W), .SEG_N(SEG_N)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .dac_word(dac_word), .seg_en(seg_en),
  .dac_upd(dac_upd), .ld_fall(ev.ld_fall), .pend(pend), .frame_ok(frame_ok)
);

// File: tb/serdac_loader_tb.sv
module serdac_loader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, ld_n = 1'b1;
  logic [15:0] dac_word;
  logic [14:0] seg_en;
  logic [11:0] ladder;
  logic        dac_upd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  serdac_loader u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .ld_n(ld_n),
    .dac_word(dac_word), .seg_en(seg_en), .ladder(ladder), .dac_upd(dac_upd)
  );

  function automatic logic [14:0] thermo(input logic [3:0] v);
    return 15'((32'd1 << v) - 1);
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_upd(input logic [15:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic frame(input logic [15:0] d, input int n);
    logic [31:0] bits;
    bits = {d, 16'h0};
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < n; i++) begin
      sdi  = (i < 32) ? bits[31-i] : 1'b0;
      sclk = 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
    end
    sclk = 1'b0;
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic strobe();
    ld_n = 1'b0;
    wait_clk(8);
    ld_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic check_hold(input logic [15:0] v, input string tag);
    checks++;
    if (dac_word !== v) begin
      errors++;
      $display("FAIL %s: dac_word=%h expected %h", tag, dac_word, v);
    end
  endtask

  // Monitor: scoreboard pop on each update pulse; R11 change tracking
  logic [15:0] last_word = 16'h0;
  int          r11_bad = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dac_upd) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6: unexpected update dac_word=%h expected no update", dac_word);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          checks++;
          if (dac_word !== e) begin
            errors++;
            $display("FAIL %s: dac_word=%h expected %h", t, dac_word, e);
          end
          checks++;
          if (seg_en !== thermo(e[15:12])) begin
            errors++;
            $display("FAIL R8: seg_en=%h expected %h", seg_en, thermo(e[15:12]));
          end
          checks++;
          if (ladder !== e[11:0]) begin
            errors++;
            $display("FAIL R9: ladder=%h expected %h", ladder, e[11:0]);
          end
        end
      end else if (dac_word !== last_word) begin
        r11_bad++;
        $display("FAIL R11: dac_word=%h changed without pulse expected %h", dac_word, last_word);
      end
      last_word = dac_word;
    end
  end

  initial begin
    wait_clk(5);
    // R7: reset state
    checks++;
    if (dac_word !== 16'h0 || seg_en !== 15'h0 || ladder !== 12'h0 || dac_upd !== 1'b0) begin
      errors++;
      $display("FAIL R7: word=%h seg=%h lad=%h upd=%b expected all zero",
               dac_word, seg_en, ladder, dac_upd);
    end
    rst_n = 1'b1;
    wait_clk(8);

    // R3, R2: direct transfer with load low
    ld_n = 1'b0;
    wait_clk(8);
    expect_upd(16'hA5C3, "R3");
    frame(16'hA5C3, 16);
    check_hold(16'hA5C3, "R2");

    // R1: serial clocks with select high are ignored
    sdi = 1'b1;
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
    end
    expect_upd(16'h0F0F, "R1");
    frame(16'h0F0F, 16);

    // R4 then R5: deferred transfer
    ld_n = 1'b1;
    wait_clk(8);
    frame(16'h1234, 16);
    check_hold(16'h0F0F, "R4");
    expect_upd(16'h1234, "R5");
    strobe();
    // R6: strobe with nothing pending
    strobe();
    check_hold(16'h1234, "R6");

    // R10: short frame discarded, pending word kept
    frame(16'h1111, 16);
    frame(16'h00FF, 15);
    check_hold(16'h1234, "R10");
    expect_upd(16'h1111, "R10");
    strobe();
    // R10: long frame with load low discarded
    ld_n = 1'b0;
    wait_clk(8);
    frame(16'hBEEF, 17);
    check_hold(16'h1111, "R10");

    // R8, R9: decode corners
    expect_upd(16'hFFFF, "R8");
    frame(16'hFFFF, 16);
    expect_upd(16'h0000, "R8");
    frame(16'h0000, 16);
    expect_upd(16'h8001, "R9");
    frame(16'h8001, 16);
    expect_upd(16'h7ABC, "R2");
    frame(16'h7ABC, 16);

    // R5: later pending word overwrites earlier one
    ld_n = 1'b1;
    wait_clk(8);
    frame(16'h2222, 16);
    frame(16'h3333, 16);
    check_hold(16'h7ABC, "R4");
    expect_upd(16'h3333, "R5");
    strobe();
    wait_clk(10);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3: %0d updates missing expected 0", exp_q.size());
    end
    checks++;
    if (r11_bad != 0) begin
      errors++;
      $display("FAIL R11: %0d unpulsed changes expected 0", r11_bad);
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run hung expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule